// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This controller gathers a set of maskable interrupt request lines and a small group of non-maskable exception lines. It turns each rising edge into a latched pending flag, and picks one winner per decision. It then reads that winner's two-byte service address from program memory and hands it to the processor with a one-cycle strobe. Every maskable source carries its own two-bit priority field, and a value of zero in that field disables the source. A single master enable gates all maskable sources. Exceptions ignore both the master enable and the priority fields, and they always beat maskable sources.

Software configures the controller over a small register bus. When the master enable is off, the controller stays passive: software can poll the pending flags and clear them by writing ones. When a vectored interrupt is taken, the controller clears the winner's pending flag and the master enable. A return pulse from the processor sets the master enable again.

Top module: `prio_intc`

## Requirements
- R1: After reset all pending flags read 0, every priority field reads 0, the master enable reads 0 and no program memory read is issued.
- R2: A rising edge on `srcReq[i]` sets pending bit i, which reads back at bus address 0 bit i and stays set until it is cleared.
- R3: Writing address 0 clears every pending bit whose data bit is 1. A rising edge arriving in the same cycle as the clear leaves that bit set.
- R4: Address 2+i holds the 2-bit priority of source i: 0 disabled, 1 low, 2 nominal, 3 high. The pending, enabled source with the highest level wins, and a disabled source is never taken.
- R5: Among pending sources at the same level, the lower index wins.
- R6: A rising edge on `excReq[e]` latches an exception that is taken even with the master enable off. It beats every maskable source at any level, and the lower exception index wins.
- R7: Address 1 bit 0 is the master enable. While it is 0, no maskable source starts a vector fetch, and its pending flag remains readable.
- R8: Taking a vector clears the master enable and the taken source's pending bit, and leaves other pending bits alone. A `retiPulse` sets the master enable again.
- R9: The vector table entry for exception e is at VEC_BASE+2*e, and the entry for source i is at VEC_BASE+2*(NUM_EXC+i).
- R10: The fetch reads the even entry address first, as the most significant byte, then the next odd address, as the least significant byte. Memory data arrives one cycle after `memRdEn`. `vecValid` pulses for one cycle after the second byte is captured, with `vecAddr` = {MSB, LSB}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | NUM_SRC | Maskable request lines, edge detected |
| excReq | input | NUM_EXC | Non-maskable exception lines, edge detected |
| retiPulse | input | 1 | Return-from-interrupt pulse, restores master enable |
| busAddr | input | $clog2(NUM_SRC+2) | Register address |
| busWrEn | input | 1 | Register write strobe |
| busWdata | input | NUM_SRC | Register write data |
| busRdata | output | NUM_SRC | Register read data, combinational |
| memRdEn | output | 1 | Program memory read request |
| memAddr | output | MEM_AW | Program memory byte address |
| memRdata | input | 8 | Program memory byte, valid one cycle after the request |
| vecValid | output | 1 | One-cycle strobe that the service address is ready |
| vecAddr | output | 16 | Fetched service address |

## Verification
The bench builds the defaults: 20 sources, 2 exceptions and a table base of 4. With these values the highest source index, 19, is reachable, and so is its table entry at the top of the list. Both exceptions can collide with a high-priority source in the same cycle. Its program memory model returns a distinct, address-derived byte at every location. This makes a swapped MSB/LSB order, an off-by-one entry address or a wrong slot visible in the returned vector.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_HI,
    ST_FETCH_LO,
    ST_CAPTURE_LO,
    ST_VALID
  } seqState_t;

  typedef struct packed {
    logic take;
    logic rdHi;
    logic rdLo;
    logic capHi;
    logic capLo;
  } seqStrobe_t;
endpackage

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int NUM_EXC = 2,
  parameter int MEM_AW = 16,
  parameter logic [MEM_AW-1:0] VEC_BASE = 4,
  localparam int ADDR_W = $clog2(NUM_SRC + 2),
  localparam int SLOT_W = $clog2(NUM_SRC + NUM_EXC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_EXC-1:0] excReq,
  input  logic               retiPulse,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  input  seqStrobe_t         strobe,
  output logic               winValid,
  output logic               memRdEn,
  output logic [MEM_AW-1:0]  memAddr,
  input  logic [7:0]         memRdata,
  output logic [15:0]        vecAddr
);
  logic [NUM_SRC-1:0] reqPrev, pend, srcRise, takeSrcMask, clrMask;
  logic [NUM_EXC-1:0] excPrev, excPend, excRise, takeExcMask;
  logic [1:0] prio [NUM_SRC];
  logic masterEn, winIsExc, srcHit;
  logic [1:0] bestLvl;
  logic [SLOT_W-1:0] winSlot, takenSlot;
  logic [7:0] vecHi, vecLo;
  logic wrPend, wrCtrl;

  assign srcRise = srcReq & ~reqPrev;
  assign excRise = excReq & ~excPrev;
  assign wrPend = busWrEn && (busAddr == ADDR_W'(0));
  assign wrCtrl = busWrEn && (busAddr == ADDR_W'(1));

  // arbitration: exceptions first, then highest level, lower index on ties
  always_comb begin
    winSlot = '0;
    winIsExc = 1'b0;
    srcHit = 1'b0;
    bestLvl = 2'b00;
    for (int e = NUM_EXC - 1; e >= 0; e--) begin
      if (excPend[e]) begin
        winIsExc = 1'b1;
        winSlot = SLOT_W'(e);
      end
    end
    if (!winIsExc) begin
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (pend[i] && prio[i] != 2'b00 && prio[i] >= bestLvl) begin
          bestLvl = prio[i];
          winSlot = SLOT_W'(NUM_EXC + i);
          srcHit = 1'b1;
        end
      end
    end
  end
  assign winValid = winIsExc || (masterEn && srcHit);

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      takeSrcMask[i] = strobe.take && !winIsExc && (winSlot == SLOT_W'(NUM_EXC + i));
    for (int e = 0; e < NUM_EXC; e++)
      takeExcMask[e] = strobe.take && winIsExc && (winSlot == SLOT_W'(e));
  end
  assign clrMask = (wrPend ? busWdata : '0) | takeSrcMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev <= '0;
      excPrev <= '0;
      pend <= '0;
      excPend <= '0;
      masterEn <= 1'b0;
      takenSlot <= '0;
      vecHi <= '0;
      vecLo <= '0;
    end else begin
      reqPrev <= srcReq;
      excPrev <= excReq;
      pend <= (pend & ~clrMask) | srcRise;
      excPend <= (excPend & ~takeExcMask) | excRise;
      if (strobe.take) masterEn <= 1'b0;
      else if (retiPulse) masterEn <= 1'b1;
      else if (wrCtrl) masterEn <= busWdata[0];
      if (strobe.take) takenSlot <= winSlot;
      if (strobe.capHi) vecHi <= memRdata;
      if (strobe.capLo) vecLo <= memRdata;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gen_prio
    always_ff @(posedge clk) begin
      if (!rstN) prio[g] <= 2'b00;
      else if (busWrEn && busAddr == ADDR_W'(g + 2)) prio[g] <= busWdata[1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(0)) busRdata = pend;
    else if (busAddr == ADDR_W'(1)) busRdata[0] = masterEn;
    for (int i = 0; i < NUM_SRC; i++)
      if (busAddr == ADDR_W'(i + 2)) busRdata[1:0] = prio[i];
  end

  assign memRdEn = strobe.rdHi | strobe.rdLo;
  assign memAddr = VEC_BASE + (MEM_AW'(takenSlot) << 1) + MEM_AW'(strobe.rdLo);
  assign vecAddr = {vecHi, vecLo};

  assert_exc_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && excPend != '0) |=> (takenSlot < SLOT_W'(NUM_EXC)));
  assert_master_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> !masterEn);
  assert_polled_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && excPend == '0) |-> masterEn);
  assert_pend_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!wrPend && !strobe.take) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: rtl/intc_seq_ctrl.sv
module intc_seq_ctrl
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       winValid,
  output seqStrobe_t strobe,
  output logic       vecValid
);
  seqState_t state, stateNext;

  always_comb begin
    strobe = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (winValid) begin
        strobe.take = 1'b1;
        stateNext = ST_FETCH_HI;
      end
      ST_FETCH_HI: begin
        strobe.rdHi = 1'b1;
        stateNext = ST_FETCH_LO;
      end
      ST_FETCH_LO: begin
        strobe.rdLo = 1'b1;
        strobe.capHi = 1'b1;
        stateNext = ST_CAPTURE_LO;
      end
      ST_CAPTURE_LO: begin
        strobe.capLo = 1'b1;
        stateNext = ST_VALID;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign vecValid = (state == ST_VALID);

  assert_two_reads_R10: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> ($past(strobe.rdHi, 3) && $past(strobe.rdLo, 2) && $past(strobe.capLo)));
  assert_take_idle_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> !strobe.take);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 20,
  parameter int NUM_EXC = 2,
  parameter int MEM_AW = 16,
  parameter logic [MEM_AW-1:0] VEC_BASE = 4,
  localparam int ADDR_W = $clog2(NUM_SRC + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_EXC-1:0] excReq,
  input  logic               retiPulse,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [NUM_SRC-1:0] busWdata,
  output logic [NUM_SRC-1:0] busRdata,
  output logic               memRdEn,
  output logic [MEM_AW-1:0]  memAddr,
  input  logic [7:0]         memRdata,
  output logic               vecValid,
  output logic [15:0]        vecAddr
);
  seqStrobe_t strobe;
  logic winValid;

  intc_datapath #(.NUM_SRC(NUM_SRC), .NUM_EXC(NUM_EXC), .MEM_AW(MEM_AW), .VEC_BASE(VEC_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .excReq(excReq), .retiPulse(retiPulse),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWdata(busWdata), .busRdata(busRdata),
    .strobe(strobe), .winValid(winValid), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdata(memRdata), .vecAddr(vecAddr)
  );

  intc_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .winValid(winValid), .strobe(strobe), .vecValid(vecValid)
  );
endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  localparam int NS = 20;
  localparam int NE = 2;
  localparam logic [15:0] BASE = 16'd4;

  logic clk = 0, rstN = 0;
  logic [NS-1:0] srcReq = '0;
  logic [NE-1:0] excReq = '0;
  logic retiPulse = 0, busWrEn = 0;
  logic [4:0] busAddr = '0;
  logic [NS-1:0] busWdata = '0, busRdata;
  logic memRdEn, vecValid;
  logic [15:0] memAddr, vecAddr;
  logic [7:0] memRdata = '0;
  int errors = 0, checks = 0, rdCount = 0, cycles = 0;
  logic [15:0] lastRd = '0, prevRd = '0;

  prio_intc u_prio_intc (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .excReq(excReq), .retiPulse(retiPulse),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWdata(busWdata), .busRdata(busRdata),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdata(memRdata),
    .vecValid(vecValid), .vecAddr(vecAddr)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] ^ 8'h5A ^ {a[11:8], 4'h3};
  endfunction

  function automatic logic [15:0] entry(input int slot);
    return BASE + 16'(2 * slot);
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memRdEn) begin
      memRdata <= mb(memAddr);
      prevRd <= lastRd;
      lastRd <= memAddr;
      rdCount <= rdCount + 1;
    end
  end

  initial begin
    wait (cycles >= 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, act=%0d cycles exp=<50000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input int a, input int d);
    @(negedge clk);
    busAddr = 5'(a); busWdata = NS'(d); busWrEn = 1;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rdReg(input int a, output int v);
    @(negedge clk);
    busAddr = 5'(a);
    #1 v = int'(busRdata);
  endtask

  task automatic waitVec(output bit got, output logic [15:0] a);
    got = 0; a = '0;
    for (int k = 0; k < 16 && !got; k++) begin
      @(negedge clk);
      if (vecValid) begin got = 1; a = vecAddr; end
    end
  endtask

  task automatic expectVec(input int slot, input string tag);
    bit got; logic [15:0] a, exp;
    exp = {mb(entry(slot)), mb(entry(slot) + 16'd1)};
    waitVec(got, a);
    check(got && a == exp, tag, int'(a), int'(exp));
    check(prevRd == entry(slot) && lastRd == entry(slot) + 16'd1,
          "R9 R10 entry read order", int'(prevRd), int'(entry(slot)));
  endtask

  // idxA, prioA, idxB, prioB, winning source
  localparam int NC = 6;
  localparam int TBL [NC][5] = '{
    '{3, 1, 7, 3, 7},
    '{3, 2, 7, 2, 3},
    '{19, 3, 0, 2, 19},
    '{5, 0, 6, 1, 6},
    '{0, 1, 1, 1, 0},
    '{12, 3, 2, 3, 2}
  };

  initial begin
    int v, rc;
    bit got;
    logic [15:0] a;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rdReg(0, v); check(v == 0, "R1 pending after reset", v, 0);
    rdReg(1, v); check(v == 0, "R1 master after reset", v, 0);
    rdReg(2 + 19, v); check(v == 0, "R1 priority after reset", v, 0);
    repeat (4) @(negedge clk);
    check(rdCount == 0 && !vecValid, "R1 no fetch after reset", rdCount, 0);

    for (int c = 0; c < NC; c++) begin
      int ea, eb, ew, rem;
      ea = 1 << TBL[c][0]; eb = 1 << TBL[c][2]; ew = 1 << TBL[c][4];
      wrReg(2 + TBL[c][0], TBL[c][1]);
      wrReg(2 + TBL[c][2], TBL[c][3]);
      @(negedge clk); srcReq = NS'(ea | eb);
      @(negedge clk); srcReq = '0;
      rdReg(0, v); check(v == (ea | eb), "R2 edge sets pending", v, ea | eb);
      wrReg(1, 1);
      expectVec(NE + TBL[c][4], "R4 R5 winner vector");
      rem = (ea | eb) & ~ew;
      rdReg(0, v); check(v == rem, "R8 taken pending cleared", v, rem);
      rdReg(1, v); check(v == 0, "R8 master cleared on take", v, 0);
      wrReg(0, 'hFFFFF);
      wrReg(2 + TBL[c][0], 0);
      wrReg(2 + TBL[c][2], 0);
    end

    // R7 polled mode: no redirect, flag readable
    wrReg(2 + 9, 3);
    rc = rdCount;
    @(negedge clk); srcReq[9] = 1;
    @(negedge clk); srcReq[9] = 0;
    waitVec(got, a);
    check(!got && rdCount == rc, "R7 no fetch with master off", rdCount, rc);
    rdReg(0, v); check(v == (1 << 9), "R7 pending readable", v, 1 << 9);
    wrReg(0, 1 << 9);
    rdReg(0, v); check(v == 0, "R3 write one clears", v, 0);
    // R3 edge beats same-cycle clear
    @(negedge clk);
    busAddr = 0; busWdata = NS'(1 << 10); busWrEn = 1; srcReq[10] = 1;
    @(negedge clk);
    busWrEn = 0; srcReq[10] = 0;
    rdReg(0, v); check(v == (1 << 10), "R3 edge wins over clear", v, 1 << 10);
    wrReg(0, 1 << 10);
    wrReg(2 + 9, 0);

    // R6 exception taken with master off
    @(negedge clk); excReq[0] = 1;
    @(negedge clk); excReq[0] = 0;
    expectVec(0, "R6 exception non-maskable");

    // R6 exception beats a high source arriving together
    wrReg(2 + 4, 3);
    @(negedge clk); srcReq[4] = 1;
    @(negedge clk); srcReq[4] = 0;
    @(negedge clk);
    busAddr = 1; busWdata = NS'(1); busWrEn = 1; excReq[1] = 1;
    @(negedge clk);
    busWrEn = 0; excReq[1] = 0;
    expectVec(1, "R6 exception over high priority");
    rdReg(0, v); check(v == (1 << 4), "R8 other pending kept", v, 1 << 4);
    rdReg(1, v); check(v == 0, "R8 master cleared by exception", v, 0);
    // R8 return pulse re-enables, source 4 now taken
    @(negedge clk); retiPulse = 1;
    @(negedge clk); retiPulse = 0;
    expectVec(NE + 4, "R8 retiPulse restores master");
    wrReg(2 + 4, 0);
    @(negedge clk); retiPulse = 1;
    @(negedge clk); retiPulse = 0;
    rdReg(1, v); check(v == 1, "R8 master set by retiPulse", v, 1);
    rdReg(0, v); check(v == 0, "R2 nothing left pending", v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule